// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block is the coherence controller of one small direct-mapped, write-through cache that shares an atomic bus with other caches. Each line holds a tag, a data word and a single state bit, Valid or Invalid. A processor-side port takes single-word reads and writes. A bus-side port asks an external arbiter for the bus with a request/grant handshake and then issues one read or one write transaction. A separate snoop port shows the transactions that other caches put on the same bus.

A read that finds a Valid line with a matching tag completes locally. Any other read fetches the word over the bus, fills the line and marks it Valid. Every write goes out on the bus. A write updates the local copy only when the line already holds that address, and it never allocates a line. When another cache writes an address that this cache holds, the line drops to Invalid. Because the bus is atomic, all caches see writes and the invalidations they cause in bus order.

The snoop path and the processor path share the tag lookup. In any cycle with a snoop, the snoop takes the lookup and a new processor request waits one cycle.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, bus_req, mst_valid and cpu_ready are low. After reset every line is Invalid, so the first read of any address misses.
- R2: A read whose line is Invalid, or whose line holds a different tag, makes exactly one bus transaction with mst_write=0 and mst_addr equal to the request address. It returns bus_rdata on cpu_rdata, fills the line and marks it Valid. A line index is addr[IDX_W-1:0] and a tag is addr[ADDR_W-1:IDX_W].
- R3: A read to a Valid line with a matching tag makes no bus transaction. cpu_ready is high in the cycle after the request is accepted, and cpu_rdata carries the cached word.
- R4: Every write makes exactly one bus transaction with mst_write=1, mst_addr and mst_wdata equal to the request, whether the line is Valid or not.
- R5: A write to an Invalid line, or to a line holding another tag, leaves the cache unchanged: the line does not allocate, and a later read of that address misses.
- R6: A write to a Valid line with a matching tag also updates the local word, so a later read hits and returns the written value.
- R7: A snoop with snp_write=1 whose address matches a Valid line makes that line Invalid from the next cycle on. A snoop read, or a snoop write with a different tag, leaves the line unchanged.
- R8: In a cycle with snp_valid=1, the controller stays idle and does not accept a new processor request. The snoop update lands first, and the processor lookup runs one cycle later against the updated state.
- R9: mst_valid is high only while bus_gnt is high. bus_req stays high from request until bus_done. The command fields stay stable until bus_done. cpu_ready is a one-cycle pulse.
- R10: If a remote write invalidates a line while this cache waits for the grant to write the same address, the write still goes out but does not revive the line, so the next read misses.
- R11: A read to an index that holds another tag replaces the line. A read of the old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| mst_valid | output | 1 | Own transaction on the bus |
| mst_write | output | 1 | 1 = bus write, 0 = bus read |
| mst_addr | output | ADDR_W | Transaction address |
| mst_wdata | output | DATA_W | Transaction write data |
| bus_done | input | 1 | Transaction complete |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |
| snp_valid | input | 1 | A transaction from another cache is visible |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
Two functions can fall in the same cycle. A snoop can arrive in the same cycle as a new processor request, and it can arrive while a write waits for its grant. The bench raises snp_valid on the edge where cpu_req first appears, aimed at a different line or at the requested line. A different line must give a hit delayed to two cycles. The requested line must turn the read into a miss that returns the remote value. A remote write injected during the grant wait must leave the line Invalid after the local write, and the next read must miss.

// File: rtl/wtsc_pkg.sv
// Package: shared types for the write-through snoop controller.
// Assumes: nothing beyond IEEE 1800-2017.
package wtsc_pkg;

    // Processor-side sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a processor request
        ST_REQ  = 2'd1,   // asking the arbiter for the bus
        ST_XFER = 2'd2,   // own transaction on the bus
        ST_RESP = 2'd3    // one-cycle completion towards the processor
    } wtsc_state_e;

endpackage

// File: rtl/wtsc_line_store.sv
// Module: line store holding state bit, tag and data for each line.
// Two read ports: one for the processor lookup, one for the snoop lookup.
// Write ports: fill (sets Valid), local update (data only) and invalidate.
// Assumes: invalidate and fill of the same line never coincide, since the
// bus is atomic. If they did, invalidate would win, which is the safe choice.
module wtsc_line_store #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output logic              sn_valid,
    output logic [TAG_W-1:0]  sn_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    output logic [LINES-1:0]  valid_vec
);

    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Match each write port against this line's index
        logic hit_fill, hit_upd, hit_inv;
        assign hit_fill = fill_en && (fill_idx == IDX_W'(g));
        assign hit_upd  = upd_en  && (upd_idx  == IDX_W'(g));
        assign hit_inv  = inv_en  && (inv_idx  == IDX_W'(g));

        // State bit: reset to Invalid, snoop invalidate first, then fill
        always_ff @(posedge clk) begin
            if (!rst_n)        valid_vec[g] <= 1'b0;
            else if (hit_inv)  valid_vec[g] <= 1'b0;
            else if (hit_fill) valid_vec[g] <= 1'b1;
        end

        // Tag: written only by a fill
        always_ff @(posedge clk) begin
            if (hit_fill) tag_q[g] <= fill_tag;
        end

        // Data: written by a fill or by a write hit
        always_ff @(posedge clk) begin
            if (hit_fill)     data_q[g] <= fill_data;
            else if (hit_upd) data_q[g] <= upd_data;
        end
    end

    // Processor lookup read port
    always_comb begin
        lk_valid = valid_vec[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_data  = data_q[lk_idx];
    end

    // Snoop lookup read port
    always_comb begin
        sn_valid = valid_vec[sn_idx];
        sn_tag   = tag_q[sn_idx];
    end

endmodule

// File: rtl/wtsc_snoop_match.sv
// Module: snoop path. It splits the snooped address, compares the tag with
// the stored one and raises an invalidate for a remote write that hits.
// Assumes: the snoop port carries only transactions of other caches.
module wtsc_snoop_match #(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  sn_idx,
    input  logic              sn_valid,
    input  logic [TAG_W-1:0]  sn_tag,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx,
    output logic              snp_busy
);

    logic [TAG_W-1:0] snp_tag;
    logic             tag_eq;

    // Address split for the snoop lookup
    always_comb begin
        sn_idx  = snp_addr[IDX_W-1:0];
        snp_tag = snp_addr[ADDR_W-1:IDX_W];
    end

    // Hit detection and invalidate request
    always_comb begin
        tag_eq   = (sn_tag == snp_tag);
        inv_en   = snp_valid && snp_write && sn_valid && tag_eq;
        inv_idx  = sn_idx;
        snp_busy = snp_valid;
    end

endmodule

// File: rtl/wtsc_req_fsm.sv
// Module: processor-side sequencer and bus master. It looks up the line,
// completes read hits locally and sends misses and all writes to the bus
// through the req/gnt handshake, then updates the line when done.
// Assumes: cpu_req is held until cpu_ready. The arbiter keeps bus_gnt high
// until bus_done. bus_done arrives only while mst_valid is high.
module wtsc_req_fsm
    import wtsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_busy,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mst_valid,
    output logic              mst_write,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [DATA_W-1:0] upd_data,
    output logic              fsm_idle
);

    wtsc_state_e       state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              accept;
    logic              lk_hit;
    logic [TAG_W-1:0]  cur_tag;
    logic              done_now;

    // Lookup index: live address when idle, latched address otherwise
    always_comb begin
        if (state_q == ST_IDLE) begin
            lk_idx  = cpu_addr[IDX_W-1:0];
            cur_tag = cpu_addr[ADDR_W-1:IDX_W];
        end else begin
            lk_idx  = addr_q[IDX_W-1:0];
            cur_tag = addr_q[ADDR_W-1:IDX_W];
        end
        lk_hit = lk_valid && (lk_tag == cur_tag);
    end

    // A request is taken only when idle and no snoop owns the lookup
    always_comb begin
        accept   = (state_q == ST_IDLE) && cpu_req && !snp_busy;
        done_now = (state_q == ST_XFER) && bus_done;
    end

    // Next-state and read-data selection
    always_comb begin
        state_d = state_q;
        rdata_d = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!cpu_we && lk_hit) begin
                        state_d = ST_RESP;
                        rdata_d = lk_data;
                    end else begin
                        state_d = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (bus_done) begin
                    state_d = ST_RESP;
                    if (!we_q) rdata_d = bus_rdata;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and read data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Capture the accepted request for the bus phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= cpu_we;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end

    // Line-store updates at the end of an own transaction
    always_comb begin
        fill_en   = done_now && !we_q;
        fill_idx  = addr_q[IDX_W-1:0];
        fill_tag  = addr_q[ADDR_W-1:IDX_W];
        fill_data = bus_rdata;
        upd_en    = done_now && we_q && lk_hit;
        upd_idx   = addr_q[IDX_W-1:0];
        upd_data  = wdata_q;
    end

    // Port outputs decoded from the state
    always_comb begin
        cpu_ready = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
        bus_req   = (state_q == ST_REQ) || (state_q == ST_XFER);
        mst_valid = (state_q == ST_XFER);
        mst_write = we_q;
        mst_addr  = addr_q;
        mst_wdata = wdata_q;
        fsm_idle  = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/wt_snoop_ctrl.sv
// Module: top of the write-through invalidate snoop controller. It ties
// the line store, the snoop path and the processor sequencer together.
// Assumes: an atomic shared bus and an external arbiter and memory.
module wt_snoop_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mst_valid,
    output logic              mst_write,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr
);

    logic [IDX_W-1:0]  lk_idx, sn_idx, fill_idx, upd_idx, inv_idx;
    logic              lk_valid, sn_valid;
    logic [TAG_W-1:0]  lk_tag, sn_tag, fill_tag;
    logic [DATA_W-1:0] lk_data, fill_data, upd_data;
    logic              fill_en, upd_en, inv_en, snp_busy, fsm_idle;
    logic [LINES-1:0]  valid_vec;

    wtsc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .sn_idx(sn_idx), .sn_valid(sn_valid), .sn_tag(sn_tag),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
        .inv_en(inv_en), .inv_idx(inv_idx), .valid_vec(valid_vec)
    );

    wtsc_snoop_match #(.ADDR_W(ADDR_W), .LINES(LINES)) u_snoop (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .sn_idx(sn_idx), .sn_valid(sn_valid), .sn_tag(sn_tag),
        .inv_en(inv_en), .inv_idx(inv_idx), .snp_busy(snp_busy)
    );

    wtsc_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .snp_busy(snp_busy),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mst_valid(mst_valid),
        .mst_write(mst_write), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data), .fsm_idle(fsm_idle)
    );

endmodule

// File: rtl/wtsc_checker.sv
// Module: protocol and state assertions for wt_snoop_ctrl, attached by bind.
// Assumes: the bound instance exposes fsm_idle, inv_en, inv_idx and valid_vec.
module wtsc_checker #(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_done,
    input logic              mst_valid,
    input logic              mst_write,
    input logic [ADDR_W-1:0] mst_addr,
    input logic              snp_valid,
    input logic              snp_write,
    input logic              fsm_idle,
    input logic              inv_en,
    input logic [IDX_W-1:0]  inv_idx,
    input logic [LINES-1:0]  valid_vec
);

    // R1: outputs are quiet after a reset edge
    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !mst_valid && !cpu_ready));

    // R7: a hitting remote write clears the line on the next edge
    p_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_vec[$past(inv_idx)]);

    // R7: a snooped read never invalidates
    p_snp_read_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_write) |-> !inv_en);

    // R8: an idle controller stays idle in a snoop cycle
    p_snoop_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && snp_valid) |=> fsm_idle);

    // R9: own transaction only under grant
    p_gnt_before_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mst_valid |-> (bus_gnt && bus_req));

    // R9: request held until the transaction completes
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> bus_req);

    // R9: command fields stable during the transaction
    p_cmd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_valid && !bus_done) |=> (mst_valid && $stable(mst_addr) && $stable(mst_write)));

    // R9: completion is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

endmodule

bind wt_snoop_ctrl wtsc_checker #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .mst_valid(mst_valid),
    .mst_write(mst_write), .mst_addr(mst_addr), .snp_valid(snp_valid),
    .snp_write(snp_write), .fsm_idle(fsm_idle), .inv_en(inv_en),
    .inv_idx(inv_idx), .valid_vec(valid_vec)
);

// File: tb/test_wt_snoop_ctrl.sv
module test_wt_snoop_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NL = 4;
    localparam int NA = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, mst_valid, mst_write;
    logic [AW-1:0] mst_addr;
    logic [DW-1:0] mst_wdata;
    logic bus_gnt = 0, bus_done = 0;
    logic [DW-1:0] bus_rdata = '0;
    logic snp_valid = 0, snp_write = 0;
    logic [AW-1:0] snp_addr = '0;

    always #5 clk = ~clk;

    wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_wt_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mst_valid(mst_valid), .mst_write(mst_write), .mst_addr(mst_addr),
        .mst_wdata(mst_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] mem [NA];
    bit            mv  [NL];
    int            mt  [NL];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Remote transaction: memory and model of this cache follow it
    task automatic remote(input int a, input bit wr);
        if (wr) begin
            mem[a] = mem[a] + 16'h1111;
            if (mv[a % NL] && mt[a % NL] == a / NL) mv[a % NL] = 0;
        end
    endtask

    // mode 0: no snoop; 1: snoop with the request; 2: snoop during grant wait
    task automatic do_op(input bit we, input int a, input logic [DW-1:0] wd,
                         input int mode, input int sa, input bit swr,
                         output logic [DW-1:0] rd, output int ntx, output int lat);
        int waitc;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
        ntx = 0; lat = 0; waitc = 0; rd = '0;
        if (mode == 1) begin
            snp_valid = 1; snp_write = swr; snp_addr = AW'(sa); remote(sa, swr);
        end
        forever begin
            @(negedge clk);
            lat++;
            snp_valid = 0;
            if (cpu_ready) begin
                rd = cpu_rdata; cpu_req = 0; bus_done = 0; bus_gnt = 0;
                break;
            end
            if (lat > 60) begin
                chk(0, "watchdog R9", lat, 60);
                cpu_req = 0; bus_done = 0; bus_gnt = 0;
                break;
            end
            if (bus_done) begin
                bus_done = 0; bus_gnt = 0;
            end else if (mst_valid) begin
                ntx++;
                chk(bus_gnt, "R9 cmd without grant", 0, 1);
                chk(mst_addr == AW'(a), "R2/R4 bus address", int'(mst_addr), a);
                chk(mst_write == we, "R2/R4 bus command", int'(mst_write), int'(we));
                if (we) begin
                    chk(mst_wdata == wd, "R4 bus wdata", int'(mst_wdata), int'(wd));
                    mem[a] = wd;
                end else begin
                    bus_rdata = mem[a];
                end
                bus_done = 1;
            end else if (bus_req && !bus_gnt) begin
                waitc++;
                if (mode == 2 && waitc == 1) begin
                    snp_valid = 1; snp_write = swr; snp_addr = AW'(sa); remote(sa, swr);
                end
                if (waitc == 3) bus_gnt = 1;
            end
        end
    endtask

    task automatic rd_op(input int a, input int mode, input int sa, input bit swr, input string req);
        logic [DW-1:0] rd; int ntx, lat; bit miss;
        do_op(0, a, '0, mode, sa, swr, rd, ntx, lat);
        miss = !(mv[a % NL] && mt[a % NL] == a / NL);
        chk(ntx == int'(miss), {req, " bus reads"}, ntx, int'(miss));
        chk(rd == mem[a], {req, " rdata"}, int'(rd), int'(mem[a]));
        if (!miss) chk(lat == ((mode == 1) ? 2 : 1), {req, " hit latency R3"}, lat, (mode == 1) ? 2 : 1);
        if (miss) begin mv[a % NL] = 1; mt[a % NL] = a / NL; end
    endtask

    task automatic wr_op(input int a, input logic [DW-1:0] wd, input int mode, input int sa, input string req);
        logic [DW-1:0] rd; int ntx, lat;
        do_op(1, a, wd, mode, sa, 1'b1, rd, ntx, lat);
        chk(ntx == 1, {req, " R4 one bus write"}, ntx, 1);
    endtask

    // One-cycle standalone snoop
    task automatic snoop(input int a, input bit wr);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_addr = AW'(a); remote(a, wr);
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < NA; i++) mem[i] = DW'(i * 16'h0101) ^ 16'h5a3c;
        for (int i = 0; i < NL; i++) begin mv[i] = 0; mt[i] = 0; end
        repeat (3) @(negedge clk);
        chk(!bus_req && !mst_valid && !cpu_ready, "R1 reset outputs", int'(bus_req), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_req && !mst_valid && !cpu_ready, "R1 after reset", int'(cpu_ready), 0);

        // Sweep: miss/fill (R2, R11), hit (R3), write hit (R4, R6)
        for (int a = 0; a < NA; a++) begin
            rd_op(a, 0, 0, 0, "R1 R2 R11 fill");
            rd_op(a, 0, 0, 0, "R3 rehit");
            wr_op(a, DW'(a * 3 + 7), 0, 0, "R6");
            rd_op(a, 0, 0, 0, "R6 read after write hit");
        end

        // No-allocate writes to lines holding another tag (R5)
        for (int a = 0; a < 16; a++) begin
            wr_op(a, DW'(a + 16'h0400), 0, 0, "R5");
            rd_op(a, 0, 0, 0, "R5 read misses");
            rd_op(a + NL * 8, 0, 0, 0, "R11 conflict replace");
            rd_op(a, 0, 0, 0, "R11 old address misses");
        end

        // Snoop path (R7)
        for (int a = 0; a < 32; a++) begin
            rd_op(a, 0, 0, 0, "R7 fill");
            snoop(a, 0);
            rd_op(a, 0, 0, 0, "R7 snoop read keeps");
            snoop((a + NL) % NA, 1);
            rd_op(a, 0, 0, 0, "R7 other tag keeps");
            snoop(a, 1);
            rd_op(a, 0, 0, 0, "R7 remote write invalidates");
        end

        // Snoop in the request cycle (R8)
        for (int a = 0; a < 16; a++) begin
            rd_op(a, 0, 0, 0, "R8 fill");
            rd_op(a, 1, (a + 1) % NA, 1, "R8 stall other line");
            rd_op(a, 1, a, 1, "R8 snoop first same line");
        end

        // Remote write while waiting for grant (R10)
        for (int a = 0; a < 16; a++) begin
            rd_op(a, 0, 0, 0, "R10 fill");
            wr_op(a, DW'(16'h7000 + a), 2, a, "R10");
            rd_op(a, 0, 0, 0, "R10 line stays invalid");
            chk(mem[a] == DW'(16'h7000 + a), "R10 bus order", int'(mem[a]), 16'h7000 + a);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_vec++; n_bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule